// File: doc/BRIEF.md
# Virtual Interrupt List-Register Injector

This block sits between a hypervisor and one virtual CPU. It holds a small bank of list registers, and each one describes a single virtual interrupt: its ID, its priority and where it is in its life. The hypervisor writes and reads these entries, a global enable and an empty-entry map through a simple register port. The guest sees a virtual IRQ line, an acknowledge strobe that returns the ID of the interrupt being taken, and an end-of-interrupt strobe that retires an interrupt by ID.

The hypervisor injects an interrupt by writing an entry in the pending state into any free slot. The block compares every pending entry with every active entry. It raises the virtual IRQ when the best pending entry is more urgent than every interrupt the guest is already servicing. An acknowledge moves that entry to active. A matching end-of-interrupt frees the entry, and its bit in the empty map turns on again, so the hypervisor knows it can reuse the slot.

Register port map: address 0 is control (bit 0 = enable). Address 1 is the empty map, which is read-only. Addresses 4 to 4+NUM_LR-1 are the list registers, each laid out as ID in bits [9:0], priority in bits [20:16] and state in bits [31:30]. Reads return data one cycle after the read strobe.

Top module: `virq_lr_inject`

## Requirements
- R1: While control bit 0 (enable) is 0, `virq` stays low and an acknowledge returns 1023, whatever the list registers hold.
- R2: A write to address 4+i stores ID [9:0], priority [20:16] and state [31:30] into list register i. A read of that address returns the same fields, with zeros elsewhere, on `hv_rdata` one cycle after the `hv_rd_en` strobe.
- R3: Reading address 1 returns, in bits [NUM_LR-1:0], a 1 for every list register whose state is 00 (invalid) and a 0 for every other list register.
- R4: Among entries in state 01 (pending), the one with the numerically lowest priority is selected. On equal priority, the lowest list-register index is selected.
- R5: `virq` is high when the block is enabled and the selected pending priority is strictly lower in value than the priority of every entry in state 10 or 11. The output is registered, so it reflects the list-register state one cycle later.
- R6: A pending entry whose ID lies in 1020..1022 or is 1023 is never selected. An acknowledge never returns 1020, 1021 or 1022, and the value 1023 means that no interrupt was delivered.
- R7: When `gst_ack` is high and an interrupt is deliverable under R5, `gst_ack_id` shows its ID from the next cycle and that entry moves from state 01 to state 10. If nothing is deliverable, `gst_ack_id` becomes 1023 and no entry changes.
- R8: When `gst_eoi` is high, the lowest-index entry in state 10 or 11 whose ID equals `gst_eoi_id` is updated: state 10 becomes 00 and its empty bit turns on, and state 11 becomes 01. If no entry matches, nothing changes.
- R9: After reset, every list register is invalid, the empty map is all ones, enable is 0, `virq` is 0 and `gst_ack_id` is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_wr_en | input | 1 | Hypervisor register write strobe |
| hv_rd_en | input | 1 | Hypervisor register read strobe |
| hv_addr | input | AW | Hypervisor register address |
| hv_wdata | input | DW | Hypervisor write data |
| hv_rdata | output | DW | Hypervisor read data, valid one cycle after the read strobe |
| gst_ack | input | 1 | Guest acknowledge strobe |
| gst_ack_id | output | ID_W | ID returned by the latest acknowledge (1023 = none) |
| gst_eoi | input | 1 | Guest end-of-interrupt strobe |
| gst_eoi_id | input | ID_W | ID being completed |
| virq | output | 1 | Virtual IRQ to the vCPU |

## Verification
A corrupted entry state shows up two cycles later at the ports. It can appear as a `virq` level that disagrees with the pending and active priorities, or as a wrong ID or a wrong 1023 on the next acknowledge. It also shows in the empty map and in the list-register readback on the next read. The directed scenarios follow entries through pending, active and invalid, and through the pending-and-active case. They compare each ack result, each `virq` level and each readback with values worked out from the priority rules. A wrong selection, such as a lost tie-break or a reserved ID that leaks through, therefore appears on the first acknowledge that follows it.

// File: rtl/virq_pkg.sv
package virq_pkg;
  typedef enum logic [1:0] {
    LR_INVALID  = 2'b00,
    LR_PENDING  = 2'b01,
    LR_ACTIVE   = 2'b10,
    LR_PEND_ACT = 2'b11
  } lr_state_e;

  localparam int DEF_NUM_LR = 4;
  localparam int DEF_ID_W   = 10;
  localparam int DEF_PRIO_W = 5;

  localparam int FLD_ID_LSB   = 0;
  localparam int FLD_PRIO_LSB = 16;
  localparam int FLD_ST_LSB   = 30;

  localparam int REG_CTRL  = 0;
  localparam int REG_EMPTY = 1;
  localparam int REG_LR0   = 4;
endpackage

// File: rtl/lr_bank.sv
module lr_bank
  import virq_pkg::*;
#(
  parameter int NUM_LR = DEF_NUM_LR,
  parameter int ID_W   = DEF_ID_W,
  parameter int PRIO_W = DEF_PRIO_W,
  parameter int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_LR-1:0]                wr_sel,
  input  logic [ID_W-1:0]                  wr_id,
  input  logic [PRIO_W-1:0]                wr_prio,
  input  logic [1:0]                       wr_state,
  input  logic                             ack_fire,
  input  logic [IDX_W-1:0]                 ack_idx,
  input  logic                             eoi_req,
  input  logic [ID_W-1:0]                  eoi_id,
  output logic [NUM_LR-1:0][ID_W-1:0]      ids,
  output logic [NUM_LR-1:0][PRIO_W-1:0]    prios,
  output logic [NUM_LR-1:0][1:0]           states,
  output logic                             eoi_frees
);
  logic [NUM_LR-1:0][ID_W-1:0]   id_q;
  logic [NUM_LR-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_LR-1:0][1:0]        st_q;

  logic [NUM_LR-1:0] eoi_hit;
  logic              eoi_any;
  logic [IDX_W-1:0]  eoi_idx;

  // lowest-index active entry carrying the completed ID
  always_comb begin
    eoi_any = 1'b0;
    eoi_idx = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      eoi_hit[i] = st_q[i][1] && (id_q[i] == eoi_id);
      if (eoi_hit[i] && !eoi_any) begin
        eoi_any = 1'b1;
        eoi_idx = IDX_W'(i);
      end
    end
  end

  assign eoi_frees = eoi_req && eoi_any && (st_q[eoi_idx] == LR_ACTIVE)
                     && !wr_sel[eoi_idx];

  generate
    for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          id_q[g]   <= '0;
          prio_q[g] <= '0;
          st_q[g]   <= LR_INVALID;
        end else if (wr_sel[g]) begin
          id_q[g]   <= wr_id;
          prio_q[g] <= wr_prio;
          st_q[g]   <= wr_state;
        end else if (ack_fire && (ack_idx == IDX_W'(g))) begin
          st_q[g] <= LR_ACTIVE;
        end else if (eoi_req && eoi_any && (eoi_idx == IDX_W'(g))) begin
          st_q[g] <= (st_q[g] == LR_ACTIVE) ? LR_INVALID : LR_PENDING;
        end
      end
    end
  endgenerate

  assign ids    = id_q;
  assign prios  = prio_q;
  assign states = st_q;
endmodule

// File: rtl/lr_arbiter.sv
module lr_arbiter
  import virq_pkg::*;
#(
  parameter int NUM_LR = DEF_NUM_LR,
  parameter int ID_W   = DEF_ID_W,
  parameter int PRIO_W = DEF_PRIO_W,
  parameter int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic [NUM_LR-1:0][ID_W-1:0]   ids,
  input  logic [NUM_LR-1:0][PRIO_W-1:0] prios,
  input  logic [NUM_LR-1:0][1:0]        states,
  output logic                          cand_valid,
  output logic [IDX_W-1:0]              cand_idx,
  output logic [ID_W-1:0]               cand_id,
  output logic [PRIO_W-1:0]             cand_prio
);
  localparam logic [ID_W-1:0] RSV_BASE = ID_W'((1 << ID_W) - 4);

  logic [NUM_LR-1:0] eligible;

  // strict less-than keeps the lower index on equal priority
  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    cand_id    = '0;
    cand_prio  = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      eligible[i] = (states[i] == LR_PENDING) && (ids[i] < RSV_BASE);
      if (eligible[i] && (!cand_valid || (prios[i] < cand_prio))) begin
        cand_valid = 1'b1;
        cand_idx   = IDX_W'(i);
        cand_id    = ids[i];
        cand_prio  = prios[i];
      end
    end
  end
endmodule

// File: rtl/lr_floor.sv
module lr_floor
  import virq_pkg::*;
#(
  parameter int NUM_LR = DEF_NUM_LR,
  parameter int PRIO_W = DEF_PRIO_W
) (
  input  logic [NUM_LR-1:0][PRIO_W-1:0] prios,
  input  logic [NUM_LR-1:0][1:0]        states,
  output logic [PRIO_W:0]               floor_prio
);
  localparam logic [PRIO_W:0] IDLE_FLOOR = {1'b1, {PRIO_W{1'b0}}};

  // most urgent priority among entries being serviced
  always_comb begin
    floor_prio = IDLE_FLOOR;
    for (int i = 0; i < NUM_LR; i++) begin
      if (states[i][1] && ({1'b0, prios[i]} < floor_prio))
        floor_prio = {1'b0, prios[i]};
    end
  end
endmodule

// File: rtl/virq_lr_inject.sv
module virq_lr_inject
  import virq_pkg::*;
#(
  parameter int NUM_LR = DEF_NUM_LR,
  parameter int ID_W   = DEF_ID_W,
  parameter int PRIO_W = DEF_PRIO_W,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hv_wr_en,
  input  logic            hv_rd_en,
  input  logic [AW-1:0]   hv_addr,
  input  logic [DW-1:0]   hv_wdata,
  output logic [DW-1:0]   hv_rdata,
  input  logic            gst_ack,
  output logic [ID_W-1:0] gst_ack_id,
  input  logic            gst_eoi,
  input  logic [ID_W-1:0] gst_eoi_id,
  output logic            virq
);
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
  localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

  logic                          en_q;
  logic [DW-1:0]                 rdata_q;
  logic [ID_W-1:0]               ack_id_q;
  logic                          virq_q;

  logic [NUM_LR-1:0]             wr_sel;
  logic [NUM_LR-1:0][ID_W-1:0]   ids;
  logic [NUM_LR-1:0][PRIO_W-1:0] prios;
  logic [NUM_LR-1:0][1:0]        states;
  logic [NUM_LR-1:0]             empty_vec;
  logic [NUM_LR-1:0]             active_vec;
  logic                          cand_valid;
  logic [IDX_W-1:0]              cand_idx;
  logic [ID_W-1:0]               cand_id;
  logic [PRIO_W-1:0]             cand_prio;
  logic [PRIO_W:0]               floor_prio;
  logic                          deliverable;
  logic                          ack_fire;
  logic                          eoi_frees;
  logic [DW-1:0]                 rd_mux;

  wire unused_wdata = ^hv_wdata;

  // write decode into list registers
  always_comb begin
    for (int i = 0; i < NUM_LR; i++)
      wr_sel[i] = hv_wr_en && (int'(hv_addr) == REG_LR0 + i);
  end

  generate
    for (genvar g = 0; g < NUM_LR; g++) begin : g_status
      assign empty_vec[g]  = (states[g] == LR_INVALID);
      assign active_vec[g] = states[g][1];
    end
  endgenerate

  lr_bank #(
    .NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (wr_sel),
    .wr_id     (hv_wdata[FLD_ID_LSB +: ID_W]),
    .wr_prio   (hv_wdata[FLD_PRIO_LSB +: PRIO_W]),
    .wr_state  (hv_wdata[FLD_ST_LSB +: 2]),
    .ack_fire  (ack_fire),
    .ack_idx   (cand_idx),
    .eoi_req   (gst_eoi),
    .eoi_id    (gst_eoi_id),
    .ids       (ids),
    .prios     (prios),
    .states    (states),
    .eoi_frees (eoi_frees)
  );

  lr_arbiter #(
    .NUM_LR(NUM_LR), .ID_W(ID_W), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_arb (
    .ids        (ids),
    .prios      (prios),
    .states     (states),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_id    (cand_id),
    .cand_prio  (cand_prio)
  );

  lr_floor #(
    .NUM_LR(NUM_LR), .PRIO_W(PRIO_W)
  ) u_floor (
    .prios      (prios),
    .states     (states),
    .floor_prio (floor_prio)
  );

  assign deliverable = en_q && cand_valid && ({1'b0, cand_prio} < floor_prio);
  assign ack_fire    = gst_ack && deliverable;

  always_comb begin
    rd_mux = '0;
    if (int'(hv_addr) == REG_CTRL) begin
      rd_mux[0] = en_q;
    end else if (int'(hv_addr) == REG_EMPTY) begin
      rd_mux[NUM_LR-1:0] = empty_vec;
    end else begin
      for (int i = 0; i < NUM_LR; i++) begin
        if (int'(hv_addr) == REG_LR0 + i) begin
          rd_mux[FLD_ID_LSB +: ID_W]     = ids[i];
          rd_mux[FLD_PRIO_LSB +: PRIO_W] = prios[i];
          rd_mux[FLD_ST_LSB +: 2]        = states[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      rdata_q  <= '0;
      ack_id_q <= SPUR_ID;
      virq_q   <= 1'b0;
    end else begin
      if (hv_wr_en && (int'(hv_addr) == REG_CTRL))
        en_q <= hv_wdata[0];
      if (hv_rd_en)
        rdata_q <= rd_mux;
      if (gst_ack)
        ack_id_q <= deliverable ? cand_id : SPUR_ID;
      virq_q <= deliverable;
    end
  end

  assign hv_rdata   = rdata_q;
  assign gst_ack_id = ack_id_q;
  assign virq       = virq_q;
endmodule

// File: rtl/virq_lr_inject_chk.sv
module virq_lr_inject_chk #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hv_wr_en,
  input logic              gst_ack,
  input logic              gst_eoi,
  input logic              en_q,
  input logic              virq,
  input logic [ID_W-1:0]   gst_ack_id,
  input logic              ack_fire,
  input logic              eoi_frees,
  input logic [NUM_LR-1:0] empty_vec,
  input logic [NUM_LR-1:0] active_vec
);
  localparam logic [ID_W-1:0] RSV_BASE = ID_W'((1 << ID_W) - 4);
  localparam logic [ID_W-1:0] SPUR_ID  = {ID_W{1'b1}};

  assert_virq_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
    virq |-> $past(en_q));

  assert_ack_id_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (gst_ack_id < RSV_BASE) || (gst_ack_id == SPUR_ID));

  assert_ack_activates_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !hv_wr_en && !gst_eoi) |=>
      ($countones(active_vec) == $past($countones(active_vec)) + 1));

  assert_eoi_frees_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_frees && !hv_wr_en) |=>
      ($countones(empty_vec) == $past($countones(empty_vec)) + 1));

  assert_idle_ack_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    (gst_ack && !ack_fire) |=> (gst_ack_id == SPUR_ID));
endmodule

bind virq_lr_inject virq_lr_inject_chk #(.NUM_LR(NUM_LR), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hv_wr_en   (hv_wr_en),
  .gst_ack    (gst_ack),
  .gst_eoi    (gst_eoi),
  .en_q       (en_q),
  .virq       (virq),
  .gst_ack_id (gst_ack_id),
  .ack_fire   (ack_fire),
  .eoi_frees  (eoi_frees),
  .empty_vec  (empty_vec),
  .active_vec (active_vec)
);

// File: tb/virq_lr_inject_tb.sv
module virq_lr_inject_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hv_wr_en = 1'b0;
  logic        hv_rd_en = 1'b0;
  logic [3:0]  hv_addr = '0;
  logic [31:0] hv_wdata = '0;
  logic [31:0] hv_rdata;
  logic        gst_ack = 1'b0;
  logic [9:0]  gst_ack_id;
  logic        gst_eoi = 1'b0;
  logic [9:0]  gst_eoi_id = '0;
  logic        virq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  virq_lr_inject u_dut (
    .clk(clk), .rst(rst), .hv_wr_en(hv_wr_en), .hv_rd_en(hv_rd_en),
    .hv_addr(hv_addr), .hv_wdata(hv_wdata), .hv_rdata(hv_rdata),
    .gst_ack(gst_ack), .gst_ack_id(gst_ack_id), .gst_eoi(gst_eoi),
    .gst_eoi_id(gst_eoi_id), .virq(virq)
  );

  function automatic logic [31:0] lrw(int id, int prio, int st);
    logic [31:0] w = '0;
    w[9:0]   = id[9:0];
    w[20:16] = prio[4:0];
    w[31:30] = st[1:0];
    return w;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk);
    hv_wr_en = 1'b1; hv_addr = addr[3:0]; hv_wdata = d;
    @(negedge clk);
    hv_wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    @(negedge clk);
    hv_rd_en = 1'b1; hv_addr = addr[3:0];
    @(negedge clk);
    hv_rd_en = 1'b0;
    d = hv_rdata;
  endtask

  task automatic ack(output int id);
    @(negedge clk);
    gst_ack = 1'b1;
    @(negedge clk);
    gst_ack = 1'b0;
    id = int'(gst_ack_id);
  endtask

  task automatic eoi(int id);
    @(negedge clk);
    gst_eoi = 1'b1; gst_eoi_id = id[9:0];
    @(negedge clk);
    gst_eoi = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 virq after reset", virq, 0);
    check("R9 ack id after reset", gst_ack_id, 1023);
    rd(1, d); check("R9 R3 empty map after reset", d, 32'hF);
    rd(0, d); check("R9 enable after reset", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d; int id;
    wr(4, lrw(40, 10, 1));
    settle();
    check("R1 virq low while disabled", virq, 0);
    ack(id); check("R1 ack while disabled", id, 1023);
    rd(4, d); check("R2 readback LR0", d, lrw(40, 10, 1));
    rd(1, d); check("R3 empty map one slot used", d, 32'hE);
  endtask

  task automatic t_enable();
    wr(0, 32'h1);
    settle();
    check("R5 virq after enable", virq, 1);
  endtask

  task automatic t_tie_and_preempt();
    logic [31:0] d; int id;
    wr(5, lrw(41, 3, 1));
    wr(6, lrw(42, 3, 1));
    ack(id); check("R4 R7 tie goes to lowest index", id, 41);
    rd(5, d); check("R7 entry now active", d, lrw(41, 3, 2));
    rd(1, d); check("R3 empty map", d, 32'h8);
    settle();
    check("R5 equal priority does not preempt", virq, 0);
    ack(id); check("R5 R7 no deliverable ack", id, 1023);
    eoi(41);
    rd(1, d); check("R8 eoi frees slot", d, 32'hA);
    settle();
    check("R5 virq after eoi", virq, 1);
    ack(id); check("R7 second ack", id, 42);
    ack(id); check("R5 lower urgency blocked", id, 1023);
    eoi(42);
    ack(id); check("R7 third ack", id, 40);
    eoi(40);
    rd(1, d); check("R8 all slots empty", d, 32'hF);
    settle();
    check("R5 virq idle", virq, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d; int id;
    wr(7, lrw(1021, 0, 1));
    settle();
    check("R6 reserved id does not raise virq", virq, 0);
    ack(id); check("R6 reserved id not returned", id, 1023);
    rd(7, d); check("R6 reserved entry untouched", d, lrw(1021, 0, 1));
    wr(7, lrw(0, 0, 0));
  endtask

  task automatic t_pend_act();
    logic [31:0] d;
    wr(5, lrw(50, 4, 3));
    eoi(99);
    rd(5, d); check("R8 mismatched eoi ignored", d, lrw(50, 4, 3));
    eoi(50);
    rd(5, d); check("R8 pending-active becomes pending", d, lrw(50, 4, 1));
    settle();
    check("R5 virq for re-pending entry", virq, 1);
  endtask

  task automatic t_priority();
    int id;
    wr(6, lrw(60, 2, 1));
    wr(4, lrw(61, 7, 1));
    ack(id); check("R4 lowest priority value wins", id, 60);
  endtask

  task automatic t_disable_again();
    int id;
    wr(0, 32'h0);
    settle();
    check("R1 virq drops when disabled", virq, 0);
    ack(id); check("R1 ack after disable", id, 1023);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_disabled();
    t_enable();
    t_tie_and_preempt();
    t_reserved();
    t_pend_act();
    t_priority();
    t_disable_again();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule